// File: doc/BRIEF.md
# Dual-Compare Bidirectional Timer Channel

One 16-bit timer channel whose counter runs up or down between two limits held in compare registers: the upper limit (compare 1) bounds upward counting and the lower limit (compare 2) bounds downward counting. Equality with the active limit reloads the counter with the opposite limit. Matching is strictly by equality. A limit the counter has already passed is therefore reached again only after the counter wraps through the end of the 16-bit range.

Compare events go to registered single-cycle match pulses and drive an output flag through a selectable output mode. The flag can be cleared, set or toggled on a compare. An alternating mode turns the channel into a variable-frequency PWM source. In that mode the flag chooses which compare register is live, the counter restarts from zero on each match, compare 1 times the low phase and compare 2 the high phase.

Software can force the flag to a given value. Each compare register has a preload register that is copied into it just after that register's own compare event, so new limits can be staged without the counter overshooting.

Top module: `dual_cmp_timer`

## Requirements
- R1: After reset the counter is 0x0000, the flag and both match pulses are 0, compare 1 is 0xFFFF and compare 2 is 0x0000.
- R2: With enable high and direction up (dir_down_i=0), the counter increments by one per clock. When it equals compare 1 it loads compare 2 on the next edge. Otherwise it wraps from 0xFFFF to 0x0000.
- R3: With direction down (dir_down_i=1), the counter decrements by one per clock. When it equals compare 2 it loads compare 1. A counter below compare 2 passes through 0x0000 to 0xFFFF.
- R4: With enable low, the counter holds its value, no match pulse is produced, and the flag changes only by force.
- R5: cmp_mode_i bit 1 enables the compare-1 match while counting up, and bit 0 enables the compare-2 match while counting down. A disabled compare still reloads the counter but raises neither a match pulse nor a flag update.
- R6: out_mode_i selects the flag action on an enabled match: 4'b0001 clears it, 4'b0010 sets it, 4'b0011 toggles it. Codes other than these and 4'b0100 leave the flag unchanged.
- R7: Alternating mode (out_mode_i=4'b0100) counts up regardless of direction and ignores cmp_mode_i. Compare 1 is live while the flag is 0 and compare 2 while it is 1. On a match the counter loads 0x0000 and the flag toggles on the same edge.
- R8: match1_o and match2_o are registered on the same edge as the flag update. Each lasts one cycle, and the two are never high together.
- R9: When force_i is high, the flag takes force_val_i on the next edge, regardless of enable and with priority over any compare action.
- R10: While match pulse n is high and load-enable n is set, compare n takes preload n on that edge. A direct compare write in the same cycle wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Count enable |
| dir_down_i | input | 1 | 1 = count down, 0 = count up |
| wdata_i | input | 16 | Write data for compare and preload registers |
| cmp1_wr_i | input | 1 | Write compare 1 |
| cmp2_wr_i | input | 1 | Write compare 2 |
| ld1_wr_i | input | 1 | Write preload 1 |
| ld2_wr_i | input | 1 | Write preload 2 |
| ld1_en_i | input | 1 | Allow preload 1 transfer |
| ld2_en_i | input | 1 | Allow preload 2 transfer |
| cmp_mode_i | input | 2 | Compare enables: bit 1 up/compare 1, bit 0 down/compare 2 |
| out_mode_i | input | 4 | Flag action select |
| force_i | input | 1 | Force strobe for the flag |
| force_val_i | input | 1 | Value loaded by force |
| cnt_o | output | 16 | Counter value |
| match1_o | output | 1 | Compare 1 match pulse |
| match2_o | output | 1 | Compare 2 match pulse |
| flag_o | output | 1 | Output flag |

## Verification
Counting down from a reset counter of zero must take exactly one step to 0xFFFF, with a compare-2 pulse. That step exposes wrong reset limits and a counter that clamps instead of reloading. In alternating mode the bench times both phases and sets the direction input to down, so a design that picks the live compare from the wrong flag state, or that honours the direction there, produces the wrong count. Preload is checked with the load enable on and off: an early, missing or unconditional transfer moves the second match by several cycles. A force issued in the same cycle as a set-on-compare event must win; a design that drops the force, or lets the compare override it, leaves the flag at 1.

// File: rtl/timer_pkg.sv
package timer_pkg;
  localparam logic [3:0] OM_CLR = 4'b0001;
  localparam logic [3:0] OM_SET = 4'b0010;
  localparam logic [3:0] OM_TGL = 4'b0011;
  localparam logic [3:0] OM_ALT = 4'b0100;
  localparam int unsigned NUM_CMP = 2;
endpackage

// File: rtl/tmr_cmp_bank.sv
module tmr_cmp_bank
  import timer_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [W-1:0]               wdata_i,
  input  logic [NUM_CMP-1:0]         cmp_wr_i,
  input  logic [NUM_CMP-1:0]         ld_wr_i,
  input  logic [NUM_CMP-1:0]         ld_en_i,
  input  logic [NUM_CMP-1:0]         evt_i,
  output logic [NUM_CMP-1:0][W-1:0]  comp_o
);
  logic [NUM_CMP-1:0][W-1:0] comp_q, ld_q;

  for (genvar g = 0; g < NUM_CMP; g++) begin : g_cmp
    // compare 1 resets to the top of range, compare 2 to the bottom
    localparam logic [W-1:0] RstVal = (g == 0) ? {W{1'b1}} : {W{1'b0}};
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        comp_q[g] <= RstVal;
        ld_q[g]   <= '0;
      end else begin
        if (ld_wr_i[g]) ld_q[g] <= wdata_i;
        if (cmp_wr_i[g])                 comp_q[g] <= wdata_i;
        else if (evt_i[g] && ld_en_i[g]) comp_q[g] <= ld_q[g];
      end
    end

    assert_preload_xfer_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (evt_i[g] && ld_en_i[g] && !cmp_wr_i[g]) |=> (comp_q[g] == $past(ld_q[g])));
  end

  assign comp_o = comp_q;
endmodule

// File: rtl/tmr_match.sv
module tmr_match
  import timer_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  logic [W-1:0] cnt_i,
  input  logic [W-1:0] comp1_i,
  input  logic [W-1:0] comp2_i,
  input  logic         en_i,
  input  logic         dir_down_i,
  input  logic [1:0]   cmp_mode_i,
  input  logic         alt_i,
  input  logic         flag_i,
  output logic         hit1_o,
  output logic         hit2_o,
  output logic [W-1:0] cnt_nxt_o
);
  logic eq1, eq2, up, wrap;
  logic [W-1:0] wrap_val;

  assign eq1 = (cnt_i == comp1_i);
  assign eq2 = (cnt_i == comp2_i);

  always_comb begin
    if (alt_i) begin
      // live compare chosen by flag state; every phase timed from zero
      up       = 1'b1;
      hit1_o   = en_i && !flag_i && eq1;
      hit2_o   = en_i &&  flag_i && eq2;
      wrap     = hit1_o || hit2_o;
      wrap_val = '0;
    end else begin
      up       = !dir_down_i;
      wrap     = en_i && (up ? eq1 : eq2);
      wrap_val = up ? comp2_i : comp1_i;
      hit1_o   = en_i &&  up && eq1 && cmp_mode_i[1];
      hit2_o   = en_i && !up && eq2 && cmp_mode_i[0];
    end
    if (!en_i)     cnt_nxt_o = cnt_i;
    else if (wrap) cnt_nxt_o = wrap_val;
    else if (up)   cnt_nxt_o = cnt_i + 1'b1;
    else           cnt_nxt_o = cnt_i - 1'b1;
  end
endmodule

// File: rtl/tmr_out_flag.sv
module tmr_out_flag
  import timer_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       hit1_i,
  input  logic       hit2_i,
  input  logic [3:0] out_mode_i,
  input  logic       force_i,
  input  logic       force_val_i,
  output logic       flag_o,
  output logic       match1_o,
  output logic       match2_o
);
  logic flag_q, flag_d, hit;

  assign hit = hit1_i || hit2_i;

  always_comb begin
    flag_d = flag_q;
    if (force_i) flag_d = force_val_i;
    else if (hit) begin
      unique case (out_mode_i)
        OM_CLR:         flag_d = 1'b0;
        OM_SET:         flag_d = 1'b1;
        OM_TGL, OM_ALT: flag_d = !flag_q;
        default:        flag_d = flag_q;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q   <= 1'b0;
      match1_o <= 1'b0;
      match2_o <= 1'b0;
    end else begin
      flag_q   <= flag_d;
      match1_o <= hit1_i;
      match2_o <= hit2_i;
    end
  end

  assign flag_o = flag_q;

  assert_force_wins_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    force_i |=> (flag_q == $past(force_val_i)));
  assert_flag_quiet_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!force_i && !hit) |=> $stable(flag_q));
  assert_set_mode_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit && !force_i && out_mode_i == OM_SET) |=> flag_q);
  assert_one_match_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({match1_o, match2_o}));
endmodule

// File: rtl/dual_cmp_timer.sv
module dual_cmp_timer
  import timer_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic         dir_down_i,
  input  logic [W-1:0] wdata_i,
  input  logic         cmp1_wr_i,
  input  logic         cmp2_wr_i,
  input  logic         ld1_wr_i,
  input  logic         ld2_wr_i,
  input  logic         ld1_en_i,
  input  logic         ld2_en_i,
  input  logic [1:0]   cmp_mode_i,
  input  logic [3:0]   out_mode_i,
  input  logic         force_i,
  input  logic         force_val_i,
  output logic [W-1:0] cnt_o,
  output logic         match1_o,
  output logic         match2_o,
  output logic         flag_o
);
  logic [NUM_CMP-1:0][W-1:0] comp;
  logic [W-1:0] cnt_q, cnt_nxt;
  logic hit1, hit2, alt;

  assign alt = (out_mode_i == OM_ALT);

  tmr_cmp_bank #(.W(W)) u_bank (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wdata_i  (wdata_i),
    .cmp_wr_i ({cmp2_wr_i, cmp1_wr_i}),
    .ld_wr_i  ({ld2_wr_i, ld1_wr_i}),
    .ld_en_i  ({ld2_en_i, ld1_en_i}),
    .evt_i    ({match2_o, match1_o}),
    .comp_o   (comp)
  );

  tmr_match #(.W(W)) u_match (
    .cnt_i      (cnt_q),
    .comp1_i    (comp[0]),
    .comp2_i    (comp[1]),
    .en_i       (en_i),
    .dir_down_i (dir_down_i),
    .cmp_mode_i (cmp_mode_i),
    .alt_i      (alt),
    .flag_i     (flag_o),
    .hit1_o     (hit1),
    .hit2_o     (hit2),
    .cnt_nxt_o  (cnt_nxt)
  );

  tmr_out_flag u_flag (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .hit1_i      (hit1),
    .hit2_i      (hit2),
    .out_mode_i  (out_mode_i),
    .force_i     (force_i),
    .force_val_i (force_val_i),
    .flag_o      (flag_o),
    .match1_o    (match1_o),
    .match2_o    (match2_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_nxt;
  end

  assign cnt_o = cnt_q;

  assert_hold_cnt_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(cnt_q));
  assert_hold_match_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (!match1_o && !match2_o));
  assert_alt_restart_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((match1_o || match2_o) && $past(alt)) |-> (cnt_q == '0));
endmodule

// File: tb/tb_dual_cmp_timer.sv
module tb_dual_cmp_timer;
  localparam int CLK_PERIOD = 10;
  localparam int W = 16;

  typedef struct packed {
    logic [15:0] c1;
    logic [15:0] c2;
    logic [1:0]  cm;
    logic [3:0]  om;
    logic        dn;
    logic [7:0]  n;
    logic [15:0] ecnt;
    logic        eflag;
  } vec_t;

  localparam int NV = 11;
  // R2 R3 R5 R6 R7 scenarios, run from reset
  localparam vec_t VECS [NV] = '{
    '{16'd5, 16'd2, 2'b10, 4'b0010, 1'b0, 8'd3, 16'd3,      1'b0},
    '{16'd5, 16'd2, 2'b10, 4'b0010, 1'b0, 8'd6, 16'd2,      1'b1},
    '{16'd5, 16'd2, 2'b10, 4'b0010, 1'b0, 8'd9, 16'd5,      1'b1},
    '{16'd5, 16'd2, 2'b00, 4'b0010, 1'b0, 8'd6, 16'd2,      1'b0},
    '{16'd5, 16'd2, 2'b01, 4'b0010, 1'b1, 8'd1, 16'hFFFF,   1'b0},
    '{16'd3, 16'd1, 2'b00, 4'b0100, 1'b0, 8'd4, 16'd0,      1'b1},
    '{16'd3, 16'd1, 2'b00, 4'b0100, 1'b0, 8'd5, 16'd1,      1'b1},
    '{16'd3, 16'd1, 2'b00, 4'b0100, 1'b1, 8'd6, 16'd0,      1'b0},
    '{16'd2, 16'd0, 2'b10, 4'b0011, 1'b0, 8'd3, 16'd0,      1'b1},
    '{16'd2, 16'd0, 2'b10, 4'b0011, 1'b0, 8'd6, 16'd0,      1'b0},
    '{16'd5, 16'd2, 2'b10, 4'b0000, 1'b0, 8'd6, 16'd2,      1'b0}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0, dn = 1'b0;
  logic [W-1:0] wdata = '0;
  logic c1_wr = 1'b0, c2_wr = 1'b0, l1_wr = 1'b0, l2_wr = 1'b0;
  logic l1_en = 1'b0, l2_en = 1'b0;
  logic [1:0] cm = 2'b00;
  logic [3:0] om = 4'b0000;
  logic frc = 1'b0, frc_val = 1'b0;
  logic [W-1:0] cnt;
  logic m1, m2, flag;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dual_cmp_timer #(.W(W)) dut (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .dir_down_i(dn), .wdata_i(wdata),
    .cmp1_wr_i(c1_wr), .cmp2_wr_i(c2_wr), .ld1_wr_i(l1_wr), .ld2_wr_i(l2_wr),
    .ld1_en_i(l1_en), .ld2_en_i(l2_en), .cmp_mode_i(cm), .out_mode_i(om),
    .force_i(frc), .force_val_i(frc_val), .cnt_o(cnt), .match1_o(m1),
    .match2_o(m2), .flag_o(flag)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    en = 0; frc = 0; c1_wr = 0; c2_wr = 0; l1_wr = 0; l2_wr = 0;
    l1_en = 0; l2_en = 0;
    rst_n = 0;
    @(negedge clk);
    rst_n = 1;
  endtask

  task automatic wr_reg(input int sel, input logic [15:0] v);
    wdata = v;
    c1_wr = (sel == 0); c2_wr = (sel == 1); l1_wr = (sel == 2); l2_wr = (sel == 3);
    @(negedge clk);
    c1_wr = 0; c2_wr = 0; l1_wr = 0; l2_wr = 0;
  endtask

  task automatic cfg(input logic [15:0] c1, input logic [15:0] c2, input logic [1:0] m,
                     input logic [3:0] o, input logic d);
    do_reset();
    cm = m; om = o; dn = d;
    wr_reg(0, c1);
    wr_reg(1, c2);
  endtask

  // enable for n edges, then sample at the following falling edge with enable dropped
  task automatic run(input int n);
    en = 1;
    repeat (n) @(posedge clk);
    @(negedge clk);
    en = 0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    // R1 reset state
    do_reset();
    chk("R1 cnt", cnt, 16'h0);
    chk("R1 flag", {15'b0, flag}, 16'h0);
    chk("R1 match", {14'b0, m1, m2}, 16'h0);

    // R1 reset limits seen through a down step from zero (R3, R5)
    cm = 2'b01; om = 4'b0010; dn = 1;
    run(1);
    chk("R1 comp1 reset reload", cnt, 16'hFFFF);
    chk("R5 down match pulse", {15'b0, m2}, 16'h1);
    chk("R6 set flag", {15'b0, flag}, 16'h1);
    run(1);
    chk("R3 down decrement", cnt, 16'hFFFE);
    chk("R8 pulse one cycle", {15'b0, m2}, 16'h0);

    for (int i = 0; i < NV; i++) begin
      cfg(VECS[i].c1, VECS[i].c2, VECS[i].cm, VECS[i].om, VECS[i].dn);
      run(int'(VECS[i].n));
      chk($sformatf("R2/R7 vec%0d cnt", i), cnt, VECS[i].ecnt);
      chk($sformatf("R6/R7 vec%0d flag", i), {15'b0, flag}, {15'b0, VECS[i].eflag});
    end

    // R4 enable low holds
    cfg(16'd5, 16'd2, 2'b10, 4'b0010, 1'b0);
    run(2);
    repeat (2) @(negedge clk);
    chk("R4 hold cnt", cnt, 16'd2);

    // R8 single-cycle match pulse
    cfg(16'd5, 16'd2, 2'b10, 4'b0010, 1'b0);
    run(6);
    chk("R8 match1 high", {15'b0, m1}, 16'h1);
    run(1);
    chk("R8 match1 low", {15'b0, m1}, 16'h0);
    chk("R2 after reload", cnt, 16'd3);

    // R9 force with enable low, then R6 clear on compare
    cfg(16'd2, 16'd0, 2'b10, 4'b0001, 1'b0);
    frc = 1; frc_val = 1;
    @(negedge clk);
    frc = 0;
    chk("R9 force to 1", {15'b0, flag}, 16'h1);
    run(3);
    chk("R6 clear flag", {15'b0, flag}, 16'h0);

    // R9 force beats a set-on-compare in the same cycle
    cfg(16'd2, 16'd0, 2'b10, 4'b0010, 1'b0);
    run(2);
    en = 1; frc = 1; frc_val = 0;
    @(negedge clk);
    en = 0; frc = 0;
    chk("R9 force priority flag", {15'b0, flag}, 16'h0);
    chk("R9 match still reported", {15'b0, m1}, 16'h1);

    // R10 preload transfer enabled
    cfg(16'd3, 16'd0, 2'b10, 4'b0010, 1'b0);
    wr_reg(2, 16'd6);
    l1_en = 1;
    run(8);
    chk("R10 preload new limit", cnt, 16'd4);
    run(3);
    chk("R10 match at preloaded limit cnt", cnt, 16'd0);
    chk("R10 match at preloaded limit", {15'b0, m1}, 16'h1);

    // R10 preload transfer disabled
    cfg(16'd3, 16'd0, 2'b10, 4'b0010, 1'b0);
    wr_reg(2, 16'd6);
    l1_en = 0;
    run(8);
    chk("R10 no transfer", cnt, 16'd0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule